// File: doc/BRIEF.md
# GPIO port with per-pin interrupt detection

This block is a 32-pin general-purpose I/O port controlled through a small memory-mapped register bus. Each pin can be turned into an output driven from a stored data value, or left as an input whose level software reads back after a two-flop synchronizer.

Every pin also has an interrupt detector. It runs on the synchronized level and on that level one clock earlier. A 2-bit trigger code selects low level, high level, rising edge or falling edge. A separate per-pin bit replaces that code with detection on both edges. Detected events latch into a status register that software clears by writing ones. A mask register decides which latched events reach the two interrupt outputs. One output serves the lower sixteen pins and the other serves the upper sixteen.

The bus is single-cycle. Writes take effect on the clock edge on which the bus is enabled with the write strobe high. Read data is driven combinationally in the cycle of the read.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, the output data, direction, both trigger registers, mask and both-edge registers read zero, and both interrupt outputs are low.
- R2: `pad_out` equals the stored output data and `pad_oe` equals the direction register. Reading the output data register returns the stored value, not the pad level.
- R3: Reading the pad register returns `pad_in` through two synchronizing flops. A change applied before edge k is still absent after edge k and is visible after edge k+1.
- R4: Pin n takes its trigger code from bits [2*(n mod 16)+1 : 2*(n mod 16)]. For pins 0..15 the code comes from the lower trigger register, and for pins 16..31 from the upper one.
- R5: Trigger codes are 00 = low level, 01 = high level, 10 = rising edge and 11 = falling edge. In the level modes the status bit is set on every cycle that the synchronized level matches.
- R6: When a pin's both-edge bit is 1, the pin flags both rising and falling edges, and its trigger code has no effect.
- R7: Writing a 1 to a status bit clears it. Writing a 0 leaves it unchanged.
- R8: When a detector event and a clear hit the same status bit in the same cycle, the bit ends up set.
- R9: Status bits latch whatever the mask holds, and the mask never alters the status register.
- R10: `irq_lo` is the OR of status AND mask over pins 0..15, and `irq_hi` is the same OR over pins 16..31. A mask bit of 1 enables the pin.
- R11: Byte offsets are 0x00 output data, 0x04 direction, 0x08 pad levels (read-only), 0x0C lower trigger, 0x10 upper trigger, 0x14 mask, 0x18 status and 0x1C both-edge. A write to 0x08 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid during a read cycle, zero otherwise |
| pad_in | input | 32 | Asynchronous pad levels |
| pad_out | output | 32 | Output drive values |
| pad_oe | output | 32 | Output enables, 1 = driven |
| irq_lo | output | 1 | Interrupt for pins 0..15 |
| irq_hi | output | 1 | Interrupt for pins 16..31 |

## Verification
On every cycle the assertions check the status-register rules: a detected event always leaves its bit set, a clear with no event always removes it, and no bit rises without an event. They also check that a fully masked port raises no interrupt and that the output enables move only on a direction write. Whether each pin reads its trigger code from the correct field, whether each code and the both-edge override produce the intended events, and the exact synchronizer latency can only be shown by the bench scenarios. For this reason the bench sweeps every pin through every mode with a fixed rise-and-fall pad pattern.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  typedef enum logic [1:0] {
    TRIG_LEVEL_LO = 2'b00,
    TRIG_LEVEL_HI = 2'b01,
    TRIG_RISE     = 2'b10,
    TRIG_FALL     = 2'b11
  } trig_mode_e;

  localparam int unsigned REG_ADDR_W = 5;

  localparam logic [REG_ADDR_W-1:0] A_DOUT    = 5'h00;
  localparam logic [REG_ADDR_W-1:0] A_DIR     = 5'h04;
  localparam logic [REG_ADDR_W-1:0] A_PADS    = 5'h08;
  localparam logic [REG_ADDR_W-1:0] A_TRIG_LO = 5'h0C;
  localparam logic [REG_ADDR_W-1:0] A_TRIG_HI = 5'h10;
  localparam logic [REG_ADDR_W-1:0] A_MASK    = 5'h14;
  localparam logic [REG_ADDR_W-1:0] A_FLAG    = 5'h18;
  localparam logic [REG_ADDR_W-1:0] A_BOTH    = 5'h1C;

  // Event decision for one pin from its mode, override bit and two samples
  function automatic logic pin_event(trig_mode_e mode, logic both, logic cur, logic prev);
    logic rise;
    logic fall;
    rise = cur & ~prev;
    fall = ~cur & prev;
    if (both) return rise | fall;
    case (mode)
      TRIG_LEVEL_LO: return ~cur;
      TRIG_LEVEL_HI: return cur;
      TRIG_RISE:     return rise;
      default:       return fall;
    endcase
  endfunction

  // Next status vector: events dominate clears
  function automatic logic [31:0] flag_next(logic [31:0] cur, logic [31:0] clr, logic [31:0] set);
    return (cur & ~clr) | set;
  endfunction

endpackage

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= async_in;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_pin_detect.sv
module gpio_pin_detect
  import gpio_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cur,
  input  logic [1:0] mode,
  input  logic       both,
  output logic       evt
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= cur;
  end

  assign evt = pin_event(trig_mode_e'(mode), both, cur, prev_q);
endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] set_vec,
  input  logic [NPINS-1:0] clr_vec,
  input  logic [NPINS-1:0] mask,
  output logic [NPINS-1:0] status_q,
  output logic             irq_lo,
  output logic             irq_hi
);
  localparam int unsigned HALF = NPINS / 2;

  logic [NPINS-1:0] pending;
  logic [31:0]      nxt;

  assign nxt = flag_next(32'(status_q), 32'(clr_vec), 32'(set_vec));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= nxt[NPINS-1:0];
  end

  assign pending = status_q & mask;
  assign irq_lo  = |pending[HALF-1:0];
  assign irq_hi  = |pending[NPINS-1:HALF];
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_en,
  input  logic                  bus_we,
  input  logic [REG_ADDR_W-1:0] bus_addr,
  input  logic [NPINS-1:0]      bus_wdata,
  output logic [NPINS-1:0]      bus_rdata,
  input  logic [NPINS-1:0]      pad_in,
  output logic [NPINS-1:0]      pad_out,
  output logic [NPINS-1:0]      pad_oe,
  output logic                  irq_lo,
  output logic                  irq_hi
);
  localparam int unsigned HALF = NPINS / 2;

  logic [NPINS-1:0] dout_q, dir_q, trig_lo_q, trig_hi_q, mask_q, both_q;
  logic [NPINS-1:0] pad_sync, set_vec, clr_vec, status_q;
  logic wr_any, wr_dout, wr_dir, wr_tlo, wr_thi, wr_mask, wr_both, wr_flag;

  assign wr_any  = bus_en & bus_we;
  assign wr_dout = wr_any && (bus_addr == A_DOUT);
  assign wr_dir  = wr_any && (bus_addr == A_DIR);
  assign wr_tlo  = wr_any && (bus_addr == A_TRIG_LO);
  assign wr_thi  = wr_any && (bus_addr == A_TRIG_HI);
  assign wr_mask = wr_any && (bus_addr == A_MASK);
  assign wr_both = wr_any && (bus_addr == A_BOTH);
  assign wr_flag = wr_any && (bus_addr == A_FLAG);
  assign clr_vec = wr_flag ? bus_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q    <= '0;
      dir_q     <= '0;
      trig_lo_q <= '0;
      trig_hi_q <= '0;
      mask_q    <= '0;
      both_q    <= '0;
    end else begin
      if (wr_dout) dout_q    <= bus_wdata;
      if (wr_dir)  dir_q     <= bus_wdata;
      if (wr_tlo)  trig_lo_q <= bus_wdata;
      if (wr_thi)  trig_hi_q <= bus_wdata;
      if (wr_mask) mask_q    <= bus_wdata;
      if (wr_both) both_q    <= bus_wdata;
    end
  end

  gpio_pad_sync #(.WIDTH(NPINS), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pad_in), .sync_out(pad_sync)
  );

  for (genvar n = 0; n < NPINS; n++) begin : g_pin
    logic [1:0] fld;
    if (n < HALF) begin : g_lo
      assign fld = trig_lo_q[2*n +: 2];
    end else begin : g_hi
      assign fld = trig_hi_q[2*(n-HALF) +: 2];
    end
    gpio_pin_detect u_det (
      .clk(clk), .rst_n(rst_n), .cur(pad_sync[n]), .mode(fld),
      .both(both_q[n]), .evt(set_vec[n])
    );
  end

  gpio_irq_status #(.NPINS(NPINS)) u_stat (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
    .mask(mask_q), .status_q(status_q), .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_en && !bus_we) begin
      case (bus_addr)
        A_DOUT:    bus_rdata = dout_q;
        A_DIR:     bus_rdata = dir_q;
        A_PADS:    bus_rdata = pad_sync;
        A_TRIG_LO: bus_rdata = trig_lo_q;
        A_TRIG_HI: bus_rdata = trig_hi_q;
        A_MASK:    bus_rdata = mask_q;
        A_FLAG:    bus_rdata = status_q;
        A_BOTH:    bus_rdata = both_q;
        default:   bus_rdata = '0;
      endcase
    end
  end

  assign pad_out = dout_q;
  assign pad_oe  = dir_q;
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk #(
  parameter int unsigned NPINS = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPINS-1:0] set_vec,
  input logic [NPINS-1:0] clr_vec,
  input logic [NPINS-1:0] status_q,
  input logic [NPINS-1:0] mask_q,
  input logic [NPINS-1:0] pad_oe,
  input logic             wr_dir,
  input logic             irq_lo,
  input logic             irq_hi
);
  AST_EVENT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((status_q & $past(set_vec)) == $past(set_vec))); // R8

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_vec & ~set_vec)) |=> ((status_q & $past(clr_vec & ~set_vec)) == '0)); // R7

  AST_NO_SPURIOUS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(set_vec)) == '0)); // R9

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> (!irq_lo && !irq_hi)); // R10

  AST_OE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_dir |=> $stable(pad_oe)); // R2
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
  .status_q(status_q), .mask_q(mask_q), .pad_oe(pad_oe), .wr_dir(wr_dir),
  .irq_lo(irq_lo), .irq_hi(irq_hi)
);

// File: tb/test_gpio_irq_port.sv
module test_gpio_irq_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, pad_in = '0, pad_out, pad_oe;
  logic        irq_lo, irq_hi;
  int          n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  gpio_irq_port i_gpio_irq_port (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  localparam logic [4:0] O_DOUT = 5'h00, O_DIR = 5'h04, O_PADS = 5'h08, O_TLO = 5'h0C,
                         O_THI = 5'h10, O_MASK = 5'h14, O_FLAG = 5'h18, O_BOTH = 5'h1C;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_en = 1'b0;
  endtask

  task automatic idle(int k);
    repeat (k) @(negedge clk);
  endtask

  // Trigger registers with pin n's 2-bit code set to m, all others rising
  function automatic logic [63:0] cfg_for(int n, logic [1:0] m);
    logic [63:0] c;
    c = {32'hAAAAAAAA, 32'hAAAAAAAA};
    c[2*n +: 2] = m;
    return c;
  endfunction

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    logic [63:0] c;
    bit expA[5], expA2[5], expB[5], expB2[5];
    expA  = '{1, 1, 1, 0, 1};
    expA2 = '{0, 1, 0, 0, 0};
    expB  = '{1, 1, 0, 1, 1};
    expB2 = '{1, 0, 0, 0, 0};

    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    rd(O_DOUT, r); chk("R1 dout", r, 0);
    rd(O_DIR, r);  chk("R1 dir", r, 0);
    rd(O_TLO, r);  chk("R1 trig_lo", r, 0);
    rd(O_THI, r);  chk("R1 trig_hi", r, 0);
    rd(O_MASK, r); chk("R1 mask", r, 0);
    rd(O_BOTH, r); chk("R1 both", r, 0);
    chk("R1 irq", {30'd0, irq_hi, irq_lo}, 0);
    // R5: default code 00 is low level, pads low -> every flag set
    idle(2);
    rd(O_FLAG, r); chk("R5 low-level default", r, 32'hFFFFFFFF);

    // R2 outputs and readback
    pad_in = 32'h0F0F0F0F;
    wr(O_DOUT, 32'hA5C3_5A3C);
    wr(O_DIR, 32'h1234_FEDC);
    chk("R2 pad_out", pad_out, 32'hA5C3_5A3C);
    chk("R2 pad_oe", pad_oe, 32'h1234_FEDC);
    rd(O_DOUT, r); chk("R2 dout readback not pads", r, 32'hA5C3_5A3C);

    // R3 synchronizer latency
    pad_in = 32'h0;
    idle(3);
    pad_in = 32'hDEAD_BEEF;
    idle(1);
    rd(O_PADS, r); chk("R3 after one edge", r, 32'h0);
    idle(1);
    rd(O_PADS, r); chk("R3 after two edges", r, 32'hDEAD_BEEF);

    // R11 pad register is read-only
    wr(O_PADS, 32'h1111_2222);
    rd(O_PADS, r); chk("R11 pads unchanged", r, 32'hDEAD_BEEF);
    rd(O_DOUT, r); chk("R11 dout unchanged", r, 32'hA5C3_5A3C);
    rd(O_DIR, r);  chk("R11 dir unchanged", r, 32'h1234_FEDC);

    // R7 clear semantics, all pins rising
    pad_in = 32'h0;
    wr(O_TLO, 32'hAAAAAAAA);
    wr(O_THI, 32'hAAAAAAAA);
    idle(3);
    wr(O_FLAG, 32'hFFFFFFFF);
    pad_in = 32'hFFFFFFFF;
    idle(4);
    rd(O_FLAG, r); chk("R5 rising all", r, 32'hFFFFFFFF);
    wr(O_FLAG, 32'h0000FFFF);
    rd(O_FLAG, r); chk("R7 clear ones", r, 32'hFFFF0000);
    wr(O_FLAG, 32'h0);
    rd(O_FLAG, r); chk("R7 zero write no effect", r, 32'hFFFF0000);

    // R9 / R10 masking
    chk("R9 masked irq", {30'd0, irq_hi, irq_lo}, 0);
    wr(O_MASK, 32'h0001_0000);
    chk("R10 upper only", {30'd0, irq_hi, irq_lo}, 32'd2);
    rd(O_FLAG, r); chk("R9 mask leaves status", r, 32'hFFFF0000);
    wr(O_MASK, 32'h0000_0001);
    chk("R10 lower pin cleared", {30'd0, irq_hi, irq_lo}, 0);
    wr(O_FLAG, 32'hFFFFFFFF);
    pad_in = 32'h0;
    wr(O_MASK, 32'h0);
    idle(4);
    wr(O_FLAG, 32'hFFFFFFFF);

    // R4 R5 R6 R8 R10 sweep over every pin and every mode
    for (int n = 0; n < 32; n++) begin
      for (int m = 0; m < 5; m++) begin
        c = cfg_for(n, (m == 4) ? 2'b00 : 2'(m));
        wr(O_TLO, c[31:0]);
        wr(O_THI, c[63:32]);
        wr(O_BOTH, (m == 4) ? (32'd1 << n) : 32'd0);
        wr(O_MASK, 32'd1 << n);
        idle(2);
        wr(O_FLAG, 32'hFFFFFFFF);
        pad_in = 32'd1 << n;
        idle(5);
        rd(O_FLAG, r);
        chk((m == 4) ? "R6 both rise" : "R4 R5 after rise", r, 32'(expA[m]) << n);
        chk("R10 irq split", {30'd0, irq_hi, irq_lo},
            expA[m] ? ((n < 16) ? 32'd1 : 32'd2) : 32'd0);
        wr(O_FLAG, 32'hFFFFFFFF);
        idle(2);
        rd(O_FLAG, r); chk("R8 level survives clear", r, 32'(expA2[m]) << n);
        pad_in = 32'h0;
        idle(5);
        rd(O_FLAG, r);
        chk((m == 4) ? "R6 both fall" : "R4 R5 after fall", r, 32'(expB[m]) << n);
        wr(O_FLAG, 32'hFFFFFFFF);
        idle(2);
        rd(O_FLAG, r); chk("R8 R5 low persists", r, 32'(expB2[m]) << n);
        wr(O_BOTH, 32'h0);
        wr(O_TLO, 32'hAAAAAAAA);
        wr(O_THI, 32'hAAAAAAAA);
        wr(O_MASK, 32'h0);
        wr(O_FLAG, 32'hFFFFFFFF);
      end
    end
    finish_run();
  end
endmodule